// File: doc/BRIEF.md
# Transceiver Power-State Sequencer

This block walks a serial transceiver macro through its power-up, power-down and reset procedures. It drives three 3-bit power-state codes (PLL, transmit lane, receive lane) and a power-on-reset line. It watches two status inputs: PLL ready and common-module OK. A single-cycle command strobe with a 2-bit operation code starts a sequence. While the sequence runs, `busy_o` stays high. When it ends, `done_o` pulses once, and `err_o` records whether a status wait ran out of time.

All waits are measured in microseconds. A free-running prescaler divides the clock by `CLKS_PER_US` to make a one-cycle microsecond tick. A status wait samples its input on its first cycle and again after every poll interval. It gives up at the first sample taken once its limit has elapsed. The poll intervals, the limits and the reset pulse width are parameters given in microseconds.

Top module: `xcvr_pwr_seq`

## Requirements
- R1: After reset, the PLL, TX and RX state outputs all hold the disable code 3'h4 and `por_o`, `busy_o`, `done_o` and `err_o` are low. The enable code is 3'h7.
- R2: Power-on (op 2'b01) first drives the PLL state to enable. It then waits for `pll_ready_i`, sampled on the first wait cycle and on every `PLL_POLL_US`-th microsecond tick after that.
- R3: Once PLL ready is seen, TX is set to enable on one clock edge and RX on the next one. RX is never enabled before TX, and TX is never enabled while the PLL is not enabled.
- R4: After RX is enabled, the block waits for `cmn_ok_i`, sampled on the first wait cycle and every `CMN_POLL_US` ticks. When it is seen high, power-on completes without error.
- R5: A wait whose sample finds its status low after at least its limit (`PLL_TMO_US` or `CMN_TMO_US` ticks) ends the sequence with `err_o` set. No later step runs, and all state outputs keep their last values.
- R6: Power-off (op 2'b10) sets TX to disable, then RX, then the PLL, on three consecutive clock edges. It completes on the PLL write.
- R7: Reset (op 2'b11) sets the PLL, then TX, then RX to disable on consecutive edges. It then raises `por_o` and drops it on the edge that ends the cycle of the `POR_US`-th tick after the rise. While `por_o` is high, all three states hold disable.
- R8: A command while `busy_o` is high has no effect, and neither does op 2'b00. `busy_o` stays high until the running sequence ends.
- R9: `err_o` stays set until the next accepted command, which clears it on its accept edge.
- R10: `done_o` is a one-cycle pulse on the edge where `busy_o` falls.
- R11: The microsecond tick occurs once every `CLKS_PER_US` clock cycles, counted from reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Operation: 01 power-on, 10 power-off, 11 reset, 00 none |
| pll_ready_i | input | 1 | PLL ready status |
| cmn_ok_i | input | 1 | Common-module OK status |
| pll_state_o | output | 3 | PLL power-state code |
| tx_state_o | output | 3 | Transmit lane power-state code |
| rx_state_o | output | 3 | Receive lane power-state code |
| por_o | output | 1 | Power-on-reset line to the macro |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| err_o | output | 1 | Sticky status-wait timeout flag |

## Verification
A wrong step pointer shows up on the state outputs within one clock edge: a code changes out of order, or a write is skipped, so the per-cycle comparison against the queue-driven model exposes it at once. A wrong poll counter or a wrong prescaler phase moves a sample edge. That shifts the cycle at which TX enable, `done_o` or `err_o` appears by at least one cycle, and the model catches the shift. A stale error flag or a lost busy state shows at the next command, when the model accepts or ignores it differently from the design.

// File: rtl/xcvr_pwr_pkg.sv
package xcvr_pwr_pkg;

    localparam logic [2:0] PWR_DIS = 3'h4;
    localparam logic [2:0] PWR_SLP = 3'h5;
    localparam logic [2:0] PWR_SNZ = 3'h6;
    localparam logic [2:0] PWR_EN  = 3'h7;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_ON   = 2'b01,
        OP_OFF  = 2'b10,
        OP_RST  = 2'b11
    } seq_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ON_PLL,
        ST_ON_WPLL,
        ST_ON_TX,
        ST_ON_RX,
        ST_ON_WCMN,
        ST_OFF_TX,
        ST_OFF_RX,
        ST_OFF_PLL,
        ST_RST_PLL,
        ST_RST_TX,
        ST_RST_RX,
        ST_RST_POR,
        ST_RST_HOLD
    } seq_st_e;

    typedef struct packed {
        seq_st_e    st;
        logic [2:0] pll;
        logic [2:0] tx;
        logic [2:0] rx;
        logic       por;
        logic       busy;
        logic       done;
        logic       err;
    } seq_ctl_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xcvr_us_tick.sv
module xcvr_us_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/xcvr_poll_timer.sv
module xcvr_poll_timer #(
    parameter int IVL_W = 10,
    parameter int US_W  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [IVL_W-1:0] ivl_i,
    input  logic [US_W-1:0]  lim_i,
    output logic             smp_o,
    output logic             lim_hit_o
);

    typedef struct packed {
        logic [IVL_W-1:0] ivl;
        logic [US_W-1:0]  elp;
        logic             first;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clr_i) begin
            tmr_d.ivl   = '0;
            tmr_d.elp   = '0;
            tmr_d.first = 1'b1;
        end else begin
            tmr_d.first = 1'b0;
            if (tick_i) begin
                if (tmr_q.elp < lim_i) tmr_d.elp = tmr_q.elp + US_W'(1);
                tmr_d.ivl = (tmr_q.ivl == ivl_i - IVL_W'(1)) ? '0 : tmr_q.ivl + IVL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign smp_o     = tmr_q.first | (tick_i & (tmr_q.ivl == ivl_i - IVL_W'(1)));
    assign lim_hit_o = ({1'b0, tmr_q.elp} + (US_W+1)'(tick_i)) >= {1'b0, lim_i};

endmodule

// File: rtl/xcvr_pwr_seq.sv
module xcvr_pwr_seq
    import xcvr_pwr_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int PLL_POLL_US = 1000,
    parameter int PLL_TMO_US  = 100000,
    parameter int CMN_POLL_US = 100,
    parameter int CMN_TMO_US  = 100000,
    parameter int POR_US      = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid_i,
    input  logic [1:0] cmd_op_i,
    input  logic       pll_ready_i,
    input  logic       cmn_ok_i,
    output logic [2:0] pll_state_o,
    output logic [2:0] tx_state_o,
    output logic [2:0] rx_state_o,
    output logic       por_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);

    localparam int MAX_US  = imax(imax(PLL_TMO_US, CMN_TMO_US), POR_US);
    localparam int MAX_IVL = imax(PLL_POLL_US, CMN_POLL_US);
    localparam int US_W    = $clog2(MAX_US + 1);
    localparam int IVL_W   = $clog2(MAX_IVL + 1);

    logic             tick;
    logic             tmr_clr;
    logic             smp;
    logic             lim_hit;
    logic [IVL_W-1:0] ivl_sel;
    logic [US_W-1:0]  lim_sel;

    seq_ctl_t ctl_d, ctl_q;

    xcvr_us_tick #(.DIV(CLKS_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    xcvr_poll_timer #(.IVL_W(IVL_W), .US_W(US_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .tick_i    (tick),
        .ivl_i     (ivl_sel),
        .lim_i     (lim_sel),
        .smp_o     (smp),
        .lim_hit_o (lim_hit)
    );

    // Interval and limit follow the wait the controller is in.
    always_comb begin
        ivl_sel = IVL_W'(1);
        lim_sel = '0;
        case (ctl_q.st)
            ST_ON_WPLL: begin
                ivl_sel = IVL_W'(PLL_POLL_US);
                lim_sel = US_W'(PLL_TMO_US);
            end
            ST_ON_WCMN: begin
                ivl_sel = IVL_W'(CMN_POLL_US);
                lim_sel = US_W'(CMN_TMO_US);
            end
            ST_RST_HOLD: lim_sel = US_W'(POR_US);
            default: ;
        endcase
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_clr    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid_i && (seq_op_e'(cmd_op_i) != OP_NONE)) begin
                    ctl_d.busy = 1'b1;
                    ctl_d.err  = 1'b0;
                    case (seq_op_e'(cmd_op_i))
                        OP_ON:   ctl_d.st = ST_ON_PLL;
                        OP_OFF:  ctl_d.st = ST_OFF_TX;
                        default: ctl_d.st = ST_RST_PLL;
                    endcase
                end
            end
            ST_ON_PLL: begin
                ctl_d.pll = PWR_EN;
                ctl_d.st  = ST_ON_WPLL;
                tmr_clr   = 1'b1;
            end
            ST_ON_WPLL: begin
                if (smp) begin
                    if (pll_ready_i) begin
                        ctl_d.st = ST_ON_TX;
                    end else if (lim_hit) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.busy = 1'b0;
                        ctl_d.done = 1'b1;
                        ctl_d.err  = 1'b1;
                    end
                end
            end
            ST_ON_TX: begin
                ctl_d.tx = PWR_EN;
                ctl_d.st = ST_ON_RX;
            end
            ST_ON_RX: begin
                ctl_d.rx = PWR_EN;
                ctl_d.st = ST_ON_WCMN;
                tmr_clr  = 1'b1;
            end
            ST_ON_WCMN: begin
                if (smp) begin
                    if (cmn_ok_i) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.busy = 1'b0;
                        ctl_d.done = 1'b1;
                    end else if (lim_hit) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.busy = 1'b0;
                        ctl_d.done = 1'b1;
                        ctl_d.err  = 1'b1;
                    end
                end
            end
            ST_OFF_TX: begin
                ctl_d.tx = PWR_DIS;
                ctl_d.st = ST_OFF_RX;
            end
            ST_OFF_RX: begin
                ctl_d.rx = PWR_DIS;
                ctl_d.st = ST_OFF_PLL;
            end
            ST_OFF_PLL: begin
                ctl_d.pll  = PWR_DIS;
                ctl_d.st   = ST_IDLE;
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
            ST_RST_PLL: begin
                ctl_d.pll = PWR_DIS;
                ctl_d.st  = ST_RST_TX;
            end
            ST_RST_TX: begin
                ctl_d.tx = PWR_DIS;
                ctl_d.st = ST_RST_RX;
            end
            ST_RST_RX: begin
                ctl_d.rx = PWR_DIS;
                ctl_d.st = ST_RST_POR;
            end
            ST_RST_POR: begin
                ctl_d.por = 1'b1;
                ctl_d.st  = ST_RST_HOLD;
                tmr_clr   = 1'b1;
            end
            ST_RST_HOLD: begin
                if (lim_hit) begin
                    ctl_d.por  = 1'b0;
                    ctl_d.st   = ST_IDLE;
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.pll  <= PWR_DIS;
            ctl_q.tx   <= PWR_DIS;
            ctl_q.rx   <= PWR_DIS;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pll_state_o = ctl_q.pll;
    assign tx_state_o  = ctl_q.tx;
    assign rx_state_o  = ctl_q.rx;
    assign por_o       = ctl_q.por;
    assign busy_o      = ctl_q.busy;
    assign done_o      = ctl_q.done;
    assign err_o       = ctl_q.err;

endmodule

// File: rtl/xcvr_pwr_seq_chk.sv
module xcvr_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid_i,
    input logic [1:0] cmd_op_i,
    input logic [2:0] pll_state_o,
    input logic [2:0] tx_state_o,
    input logic [2:0] rx_state_o,
    input logic       por_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o
);

    localparam logic [2:0] C_DIS = 3'h4;
    localparam logic [2:0] C_EN  = 3'h7;

    AST_TX_NEEDS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state_o == C_EN && $past(tx_state_o) != C_EN) |-> pll_state_o == C_EN); // R3

    AST_RX_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state_o == C_EN && $past(rx_state_o) != C_EN) |-> $past(tx_state_o) == C_EN); // R3

    AST_POR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        por_o |-> (pll_state_o == C_DIS && tx_state_o == C_DIS && rx_state_o == C_DIS)); // R7

    AST_POR_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        por_o |-> busy_o); // R7

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(cmd_valid_i && !busy_o && cmd_op_i != 2'b00)) |=> err_o); // R9

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o); // R5

endmodule

bind xcvr_pwr_seq xcvr_pwr_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .pll_state_o (pll_state_o),
    .tx_state_o  (tx_state_o),
    .rx_state_o  (rx_state_o),
    .por_o       (por_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/xcvr_pwr_seq_tb.sv
module xcvr_pwr_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int PP = 4;
    localparam int PT = 20;
    localparam int CP = 2;
    localparam int CT = 12;
    localparam int PR = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       pll_ready = 1'b0;
    logic       cmn_ok = 1'b0;
    logic [2:0] pll_state, tx_state, rx_state;
    logic       por, busy, done, err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_pwr_seq #(
        .CLKS_PER_US(N), .PLL_POLL_US(PP), .PLL_TMO_US(PT),
        .CMN_POLL_US(CP), .CMN_TMO_US(CT), .POR_US(PR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .pll_ready_i(pll_ready), .cmn_ok_i(cmn_ok),
        .pll_state_o(pll_state), .tx_state_o(tx_state), .rx_state_o(rx_state),
        .por_o(por), .busy_o(busy), .done_o(done), .err_o(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: a queue of pending actions consumed one per cycle.
    localparam int A_PLL_EN = 1, A_TX_EN = 2, A_RX_EN = 3, A_W_PLL = 4, A_W_CMN = 5;
    localparam int A_TX_DIS = 6, A_RX_DIS = 7, A_PLL_DIS = 8, A_POR_ON = 9, A_POR_HOLD = 10;

    int m_pll = 4, m_tx = 4, m_rx = 4;
    bit m_por = 0, m_busy = 0, m_done = 0, m_err = 0;
    int m_pc = 0, m_elp = 0, m_ivl = 0;
    bit m_first = 0;
    int actq[$];
    bit clr_n, done_n;

    function automatic bit is_wait(input int a);
        return a == A_W_PLL || a == A_W_CMN || a == A_POR_HOLD;
    endfunction

    task automatic advance();
        void'(actq.pop_front());
        if (actq.size() == 0) begin
            m_busy = 0;
            done_n = 1;
        end else if (is_wait(actq[0])) begin
            clr_n = 1;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pll = 4; m_tx = 4; m_rx = 4;
            m_por = 0; m_busy = 0; m_done = 0; m_err = 0;
            m_pc = 0; m_elp = 0; m_ivl = 0; m_first = 0;
            actq.delete();
        end else begin
            int tk, iv, lim;
            bit stat, smp;
            tk = (m_pc == N - 1) ? 1 : 0;
            clr_n = 0;
            done_n = 0;
            iv = 1;
            if (actq.size() != 0 && actq[0] == A_W_PLL) iv = PP;
            if (actq.size() != 0 && actq[0] == A_W_CMN) iv = CP;
            if (actq.size() == 0) begin
                if (cmd_valid && cmd_op != 2'b00) begin
                    m_busy = 1;
                    m_err = 0;
                    if (cmd_op == 2'b01)
                        actq = '{A_PLL_EN, A_W_PLL, A_TX_EN, A_RX_EN, A_W_CMN};
                    else if (cmd_op == 2'b10)
                        actq = '{A_TX_DIS, A_RX_DIS, A_PLL_DIS};
                    else
                        actq = '{A_PLL_DIS, A_TX_DIS, A_RX_DIS, A_POR_ON, A_POR_HOLD};
                end
            end else begin
                case (actq[0])
                    A_PLL_EN:  begin m_pll = 7; advance(); end
                    A_TX_EN:   begin m_tx = 7; advance(); end
                    A_RX_EN:   begin m_rx = 7; advance(); end
                    A_PLL_DIS: begin m_pll = 4; advance(); end
                    A_TX_DIS:  begin m_tx = 4; advance(); end
                    A_RX_DIS:  begin m_rx = 4; advance(); end
                    A_POR_ON:  begin m_por = 1; advance(); end
                    A_POR_HOLD: begin
                        if (m_elp + tk >= PR) begin m_por = 0; advance(); end
                    end
                    default: begin
                        stat = (actq[0] == A_W_PLL) ? pll_ready : cmn_ok;
                        lim  = (actq[0] == A_W_PLL) ? PT : CT;
                        smp  = m_first || (tk == 1 && m_ivl == iv - 1);
                        if (smp && stat) advance();
                        else if (smp && (m_elp + tk >= lim)) begin
                            m_err = 1; m_busy = 0; done_n = 1;
                            actq.delete();
                        end
                    end
                endcase
            end
            if (clr_n) begin
                m_elp = 0; m_ivl = 0; m_first = 1;
            end else begin
                m_first = 0;
                if (tk == 1) begin
                    m_elp++;
                    m_ivl = (m_ivl == iv - 1) ? 0 : m_ivl + 1;
                end
            end
            m_pc = (tk == 1) ? 0 : m_pc + 1;
            m_done = done_n;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 pll_state vs model", pll_state, m_pll);
            chk("R3 tx_state vs model", tx_state, m_tx);
            chk("R3 rx_state vs model", rx_state, m_rx);
            chk("R7 por vs model", por, m_por);
            chk("R8 busy vs model", busy, m_busy);
            chk("R10 done vs model", done, m_done);
            chk("R5 err vs model", err, m_err);
        end
    end

    task automatic issue(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 2'b00;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 600; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=completion");
            finish_run();
        end
    end

    initial begin
        int por_len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pll disable", pll_state, 4);
        chk("R1 tx disable", tx_state, 4);
        chk("R1 rx disable", rx_state, 4);
        chk("R1 por low", por, 0);
        chk("R1 busy low", busy, 0);
        chk("R1 err low", err, 0);

        // R2/R4: power-on with both statuses already high
        pll_ready = 1; cmn_ok = 1;
        issue(2'b01);
        chk("R2 busy after accept", busy, 1);
        @(negedge clk);
        chk("R2 pll enabled first", pll_state, 7);
        chk("R3 tx not yet", tx_state, 4);
        wait_idle();
        chk("R4 no error", err, 0);
        chk("R4 rx enabled", rx_state, 7);

        // R6: power-off order
        issue(2'b10);
        @(negedge clk);
        chk("R6 tx off first", tx_state, 4);
        chk("R6 rx still on", rx_state, 7);
        @(negedge clk);
        chk("R6 rx off second", rx_state, 4);
        chk("R6 pll still on", pll_state, 7);
        @(negedge clk);
        chk("R6 pll off last", pll_state, 4);
        chk("R10 done pulse", done, 1);

        // R2/R3/R4 with delayed statuses, R8 ignored command
        pll_ready = 0; cmn_ok = 0;
        issue(2'b01);
        repeat (5) @(negedge clk);
        issue(2'b11);
        chk("R8 reset ignored while busy", por, 0);
        chk("R8 busy held", busy, 1);
        repeat (15) @(negedge clk);
        chk("R3 tx waits for pll", tx_state, 4);
        pll_ready = 1;
        repeat (20) @(negedge clk);
        chk("R4 waiting for common ok", busy, 1);
        cmn_ok = 1;
        wait_idle();
        chk("R4 done without error", err, 0);
        chk("R3 tx enabled", tx_state, 7);

        // R5: PLL wait timeout
        issue(2'b10);
        wait_idle();
        pll_ready = 0; cmn_ok = 0;
        issue(2'b01);
        wait_idle();
        chk("R5 err set", err, 1);
        chk("R5 pll holds enable", pll_state, 7);
        chk("R5 tx step skipped", tx_state, 4);
        chk("R5 rx step skipped", rx_state, 4);

        // R9 / R8: sticky error, op none ignored
        repeat (10) @(negedge clk);
        chk("R9 err sticky", err, 1);
        issue(2'b00);
        chk("R8 op none ignored", busy, 0);
        chk("R9 err kept after op none", err, 1);
        issue(2'b10);
        chk("R9 err cleared on accept", err, 0);
        wait_idle();

        // R5 on common-ok timeout, then R7/R11 reset pulse
        pll_ready = 1; cmn_ok = 0;
        issue(2'b01);
        wait_idle();
        chk("R5 common timeout err", err, 1);
        chk("R5 rx holds enable", rx_state, 7);
        issue(2'b11);
        por_len = 0;
        for (int i = 0; i < 100; i++) begin
            if (por) por_len++;
            if (!busy) break;
            @(negedge clk);
        end
        chk("R7 states disabled", int'(pll_state == 4 && tx_state == 4 && rx_state == 4), 1);
        chk("R11 por width lower bound", int'(por_len >= (PR - 1) * N + 1), 1);
        chk("R11 por width upper bound", int'(por_len <= PR * N), 1);
        chk("R7 por low at end", por, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule